// File: doc/BRIEF.md
# Hash-Rehash Second-Level Translation Buffer

This block is a second-level translation lookaside buffer that keeps 4 KB, 2 MB and 1 GB page translations together in one set-associative array of flip-flops. The array is indexed by a different hash for each page size. A lookup does not search every size at once. It probes one candidate set per cycle, starting with the 4 KB hash, then the 2 MB hash, then the 1 GB hash. The lookup therefore finishes after one, two or three probe cycles. A `done_o` flag tells the requester that the answer (a hit with its stored translation, or a final miss) is valid. The requester stalls until that flag rises.

Translations are written by a page-table walker through a refill port. A refill lands in the set picked by the hash for the refilled page's own size. It takes an invalid way if the set has one, otherwise the tree pseudo-LRU victim of that set. A flush port removes entries by address space identifier (ASID) and virtual page number (VPN), or removes every entry at once.

The probe sequencer is a three-state machine:
- `ST_PROBE_4K`: the reset and idle state. It probes the live request.
- `ST_PROBE_2M`: probes the latched request with the 2 MB hash.
- `ST_PROBE_1G`: probes the latched request with the 1 GB hash.

Its transitions are:
- **advance**: 4K→2M or 2M→1G, taken on an active probe that misses.
- **finish**: back to 4K, taken on a hit from any state, or on any active probe in 1G.
- **hold**: stay in the current state while no active probe takes place.
- **abort**: back to 4K whenever a flush is requested.

A probe is active when a request is valid, no walk refill is pending and no flush is requested.

Top module: `tlb_hrh`

## Requirements
- R1: After reset every entry is invalid, and `hit_o` and `done_o` stay low while no request is presented. A lookup into the empty array ends as a miss on its third probe cycle.
- R2: A lookup that matches a valid 4 KB entry raises `hit_o` and `done_o` in its first probe cycle and returns the stored PPN, permission bits and size.
- R3: An entry hits only on the probe for its own size, coded 0 = 4 KB, 1 = 2 MB, 2 = 1 GB on `size_o` and `refill_size_i`. A 2 MB entry hits on the second probe cycle and a 1 GB entry on the third, even when an earlier probe visits a set that holds it.
- R4: A lookup that matches no entry raises `done_o` with `hit_o` low on its third probe cycle, and never earlier.
- R5: The set for a probe is the low log2(SETS) bits of the 9-bit VPN field of the probed level: bits 8:0 for 4 KB, 17:9 for 2 MB, 26:18 for 1 GB. A hit also needs every higher field down to that level, and the ASID, to equal the stored ones.
- R6: The probe sequence advances only in cycles where the request is valid, `walk_pending_i` is low and `flush_i` is low. `done_o` and `hit_o` stay low in any other cycle.
- R7: The VPN and ASID are captured on the first probe cycle. Changing them before `done_o` has no effect on the result, and the next request starts again at the 4 KB probe.
- R8: A refill writes the lowest-numbered invalid way of its set, and it uses the pseudo-LRU victim only when the set is full.
- R9: Hits and refills update the tree pseudo-LRU state of their own set only. With 4 ways, a set is filled in turn by pages A, B, C and D, and A is then hit. The next refill into that set replaces C.
- R10: A flush with zero VPN and zero ASID invalidates every entry. Any other flush invalidates the entries whose ASID equals the flush ASID and that either cover the flush VPN or were flushed with VPN zero. The flush takes effect from the next cycle.
- R11: A refill in the same cycle as a hitting probe is applied, and the hit is still reported in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Lookup request valid, held until `done_o` |
| lookup_vpn_i | input | 27 | Virtual page number to translate |
| lookup_asid_i | input | ASID_W | Address space of the lookup |
| walk_pending_i | input | 1 | Walker refill pending; freezes the probe sequence |
| hit_o | output | 1 | Translation found this cycle |
| done_o | output | 1 | All needed probes finished (hit or final miss) |
| ppn_o | output | PPN_W | Stored physical page number of the hit |
| perm_o | output | PERM_W | Stored permission bits of the hit |
| size_o | output | 2 | Page size of the hit entry |
| refill_valid_i | input | 1 | Write a translation from the walker |
| refill_vpn_i | input | 27 | VPN of the refilled page |
| refill_asid_i | input | ASID_W | ASID of the refilled page |
| refill_size_i | input | 2 | Page size of the refilled page |
| refill_ppn_i | input | PPN_W | PPN of the refilled page |
| refill_perm_i | input | PERM_W | Permission bits of the refilled page |
| flush_i | input | 1 | Flush request |
| flush_vpn_i | input | 27 | Flush VPN; zero means any address |
| flush_asid_i | input | ASID_W | Flush ASID |

## Verification
A refill and a hitting probe can occur in the same cycle. Both then write the storage and the pseudo-LRU state in that cycle. The bench provokes this by issuing a refill of a new page on the same clock edge as a lookup that hits an existing 4 KB entry. It judges the outcome by requiring that the lookup reports its hit with the old entry's PPN in that cycle, and that a later lookup of the refilled page hits. A second overlap, a walk refill pending during a probe sequence, is provoked mid-lookup. It is judged by the number of unstalled cycles counted before `done_o`.

// File: rtl/tlb_hrh_pkg.sv
package tlb_hrh_pkg;

    localparam int LVL_W = 9;
    localparam int VPN_W = 3 * LVL_W;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } page_size_e;

    typedef enum logic [1:0] {
        ST_PROBE_4K = 2'd0,
        ST_PROBE_2M = 2'd1,
        ST_PROBE_1G = 2'd2
    } probe_state_e;

    // True when a stored page of size sz covers vpn: fields from the top
    // level down to the stored page's own level must agree.
    function automatic logic vpn_covers(input logic [VPN_W-1:0] stored,
                                        input logic [1:0]       sz,
                                        input logic [VPN_W-1:0] vpn);
        logic hi, mid, lo;
        hi  = stored[3*LVL_W-1:2*LVL_W] == vpn[3*LVL_W-1:2*LVL_W];
        mid = stored[2*LVL_W-1:LVL_W]   == vpn[2*LVL_W-1:LVL_W];
        lo  = stored[LVL_W-1:0]         == vpn[LVL_W-1:0];
        case (sz)
            2'd2:    return hi;
            2'd1:    return hi && mid;
            default: return hi && mid && lo;
        endcase
    endfunction

endpackage

// File: rtl/tlb_hrh_way_match.sv
module tlb_hrh_way_match
    import tlb_hrh_pkg::*;
#(
    parameter int ASID_W = 16
) (
    input  logic              ent_valid_i,
    input  logic [1:0]        ent_size_i,
    input  logic [ASID_W-1:0] ent_asid_i,
    input  logic [VPN_W-1:0]  ent_vpn_i,
    input  logic [1:0]        probe_size_i,
    input  logic [ASID_W-1:0] probe_asid_i,
    input  logic [VPN_W-1:0]  probe_vpn_i,
    output logic              hit_o
);
    always_comb begin
        hit_o = ent_valid_i
             && (ent_size_i == probe_size_i)
             && (ent_asid_i == probe_asid_i)
             && vpn_covers(ent_vpn_i, probe_size_i, probe_vpn_i);
    end
endmodule

// File: rtl/tlb_hrh_plru.sv
module tlb_hrh_plru #(
    parameter int WAYS = 4,
    parameter int SETS = 8,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en_i,
    input  logic [IDX_W-1:0] touch_set_i,
    input  logic [WAY_W-1:0] touch_way_i,
    input  logic             fill_en_i,
    input  logic [IDX_W-1:0] fill_set_i,
    input  logic [WAY_W-1:0] fill_way_i,
    output logic [WAY_W-1:0] victim_way_o
);
    localparam int NODES = WAYS - 1;

    logic [NODES-1:0] tree_q [SETS];
    logic [NODES-1:0] tree_d [SETS];

    // Each node bit points toward the less recently used half.
    function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                               input logic [WAY_W-1:0] w);
        int n;
        n = 0;
        for (int l = 0; l < WAY_W; l++) begin
            t[n] = ~w[WAY_W-1-l];
            n = 2 * n + 1 + int'(w[WAY_W-1-l]);
        end
        return t;
    endfunction

    function automatic logic [WAY_W-1:0] victim(input logic [NODES-1:0] t);
        int n;
        n = 0;
        for (int l = 0; l < WAY_W; l++) begin
            n = 2 * n + 1 + int'(t[n]);
        end
        return WAY_W'(n - NODES);
    endfunction

    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            tree_d[s] = tree_q[s];
            if (touch_en_i && touch_set_i == IDX_W'(s))
                tree_d[s] = touch(tree_d[s], touch_way_i);
            if (fill_en_i && fill_set_i == IDX_W'(s))
                tree_d[s] = touch(tree_d[s], fill_way_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= tree_d[s];
        end
    end

    assign victim_way_o = victim(tree_q[fill_set_i]);
endmodule

// File: rtl/tlb_hrh.sv
module tlb_hrh
    import tlb_hrh_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SETS   = 8,
    parameter int ASID_W = 16,
    parameter int PPN_W  = 44,
    parameter int PERM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lookup_valid_i,
    input  logic [26:0]       lookup_vpn_i,
    input  logic [ASID_W-1:0] lookup_asid_i,
    input  logic              walk_pending_i,
    output logic              hit_o,
    output logic              done_o,
    output logic [PPN_W-1:0]  ppn_o,
    output logic [PERM_W-1:0] perm_o,
    output logic [1:0]        size_o,
    input  logic              refill_valid_i,
    input  logic [26:0]       refill_vpn_i,
    input  logic [ASID_W-1:0] refill_asid_i,
    input  logic [1:0]        refill_size_i,
    input  logic [PPN_W-1:0]  refill_ppn_i,
    input  logic [PERM_W-1:0] refill_perm_i,
    input  logic              flush_i,
    input  logic [26:0]       flush_vpn_i,
    input  logic [ASID_W-1:0] flush_asid_i
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);

    // Storage: flip-flop array, one entry per set and way.
    logic              ent_valid_q [SETS][WAYS];
    logic [1:0]        ent_size_q  [SETS][WAYS];
    logic [ASID_W-1:0] ent_asid_q  [SETS][WAYS];
    logic [VPN_W-1:0]  ent_vpn_q   [SETS][WAYS];
    logic [PPN_W-1:0]  ent_ppn_q   [SETS][WAYS];
    logic [PERM_W-1:0] ent_perm_q  [SETS][WAYS];

    probe_state_e      state_q, state_d;
    logic [VPN_W-1:0]  req_vpn_q;
    logic [ASID_W-1:0] req_asid_q;

    logic              active;
    logic [1:0]        probe_size;
    logic [VPN_W-1:0]  probe_vpn;
    logic [ASID_W-1:0] probe_asid;
    logic [IDX_W-1:0]  probe_set;
    logic [WAYS-1:0]   way_hit;
    logic              any_hit;
    logic [WAY_W-1:0]  hit_way;

    logic [IDX_W-1:0]  fill_set;
    logic [WAY_W-1:0]  fill_way, free_way, victim_way;
    logic              have_free;
    logic              flush_all;
    logic              flush_kill [SETS][WAYS];

    function automatic logic [IDX_W-1:0] set_of(input logic [VPN_W-1:0] v,
                                                input logic [1:0]       sz);
        case (sz)
            2'd1:    return v[LVL_W +: IDX_W];
            2'd2:    return v[2*LVL_W +: IDX_W];
            default: return v[IDX_W-1:0];
        endcase
    endfunction

    // ---------------- probe path ----------------
    assign active     = lookup_valid_i && !walk_pending_i && !flush_i;
    assign probe_vpn  = (state_q == ST_PROBE_4K) ? lookup_vpn_i  : req_vpn_q;
    assign probe_asid = (state_q == ST_PROBE_4K) ? lookup_asid_i : req_asid_q;
    assign probe_set  = set_of(probe_vpn, probe_size);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tlb_hrh_way_match #(.ASID_W(ASID_W)) u_match (
            .ent_valid_i  (ent_valid_q[probe_set][w]),
            .ent_size_i   (ent_size_q[probe_set][w]),
            .ent_asid_i   (ent_asid_q[probe_set][w]),
            .ent_vpn_i    (ent_vpn_q[probe_set][w]),
            .probe_size_i (probe_size),
            .probe_asid_i (probe_asid),
            .probe_vpn_i  (probe_vpn),
            .hit_o        (way_hit[w])
        );
    end

    always_comb begin
        any_hit = |way_hit;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) hit_way = WAY_W'(w);
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PROBE_4K;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (flush_i) begin
            state_d = ST_PROBE_4K;                         // abort
        end else if (active) begin
            unique case (state_q)
                ST_PROBE_4K: state_d = any_hit ? ST_PROBE_4K : ST_PROBE_2M;
                ST_PROBE_2M: state_d = any_hit ? ST_PROBE_4K : ST_PROBE_1G;
                ST_PROBE_1G: state_d = ST_PROBE_4K;
                default:     state_d = ST_PROBE_4K;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        unique case (state_q)
            ST_PROBE_4K: probe_size = PG_4K;
            ST_PROBE_2M: probe_size = PG_2M;
            ST_PROBE_1G: probe_size = PG_1G;
            default:     probe_size = PG_4K;
        endcase
        hit_o  = active && any_hit;
        done_o = active && (any_hit || state_q == ST_PROBE_1G);
        ppn_o  = ent_ppn_q[probe_set][hit_way];
        perm_o = ent_perm_q[probe_set][hit_way];
        size_o = ent_size_q[probe_set][hit_way];
    end

    // Request capture on the first probe of a sequence.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_vpn_q  <= '0;
            req_asid_q <= '0;
        end else if (state_q == ST_PROBE_4K && active && !any_hit) begin
            req_vpn_q  <= lookup_vpn_i;
            req_asid_q <= lookup_asid_i;
        end
    end

    // ---------------- refill way choice ----------------
    assign fill_set = set_of(refill_vpn_i, refill_size_i);

    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!ent_valid_q[fill_set][w]) begin
                have_free = 1'b1;
                free_way  = WAY_W'(w);
            end
        end
        fill_way = have_free ? free_way : victim_way;
    end

    tlb_hrh_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
        .clk          (clk),
        .rst_n        (rst_n),
        .touch_en_i   (hit_o),
        .touch_set_i  (probe_set),
        .touch_way_i  (hit_way),
        .fill_en_i    (refill_valid_i),
        .fill_set_i   (fill_set),
        .fill_way_i   (fill_way),
        .victim_way_o (victim_way)
    );

    // ---------------- flush selection ----------------
    assign flush_all = (flush_vpn_i == '0) && (flush_asid_i == '0);

    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                flush_kill[s][w] = flush_all
                    || ((ent_asid_q[s][w] == flush_asid_i)
                        && ((flush_vpn_i == '0)
                            || vpn_covers(ent_vpn_q[s][w], ent_size_q[s][w], flush_vpn_i)));
            end
        end
    end

    // ---------------- storage update ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    ent_valid_q[s][w] <= 1'b0;
        end else begin
            if (flush_i) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        if (flush_kill[s][w]) ent_valid_q[s][w] <= 1'b0;
            end
            if (refill_valid_i) ent_valid_q[fill_set][fill_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (refill_valid_i) begin
            ent_size_q[fill_set][fill_way] <= refill_size_i;
            ent_asid_q[fill_set][fill_way] <= refill_asid_i;
            ent_vpn_q[fill_set][fill_way]  <= refill_vpn_i;
            ent_ppn_q[fill_set][fill_way]  <= refill_ppn_i;
            ent_perm_q[fill_set][fill_way] <= refill_perm_i;
        end
    end
endmodule

// File: rtl/tlb_hrh_chk.sv
module tlb_hrh_chk
    import tlb_hrh_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         lookup_valid_i,
    input logic         walk_pending_i,
    input logic         flush_i,
    input logic         hit_o,
    input logic         done_o,
    input logic [1:0]   size_o,
    input probe_state_e state_q
);
    // R2: in the first probe, completion only happens on a hit
    p_first_probe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE_4K && done_o) |-> hit_o);

    // R3: a hit entry's size equals the size being probed
    p_size_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((state_q == ST_PROBE_4K && size_o == 2'd0)
                || (state_q == ST_PROBE_2M && size_o == 2'd1)
                || (state_q == ST_PROBE_1G && size_o == 2'd2)));

    // R4: a miss completes only on the last probe
    p_miss_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !hit_o) |-> state_q == ST_PROBE_1G);

    // R6: no progress without an active probe
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!lookup_valid_i || walk_pending_i) && !flush_i) |=> $stable(state_q));

    // R6: nothing completes while a walk refill is pending
    p_pending_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_pending_i |-> !done_o && !hit_o);

    // R7: the next request restarts at the first hash
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> state_q == ST_PROBE_4K);

    // R10: a flush aborts any sequence and reports nothing
    p_flush_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !done_o ##1 state_q == ST_PROBE_4K);
endmodule

bind tlb_hrh tlb_hrh_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lookup_valid_i (lookup_valid_i),
    .walk_pending_i (walk_pending_i),
    .flush_i        (flush_i),
    .hit_o          (hit_o),
    .done_o         (done_o),
    .size_o         (size_o),
    .state_q        (state_q)
);

// File: tb/test_tlb_hrh.sv
`timescale 1ns/1ps
module test_tlb_hrh;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup_valid_i = 1'b0;
    logic [26:0] lookup_vpn_i = '0;
    logic [15:0] lookup_asid_i = '0;
    logic        walk_pending_i = 1'b0;
    logic        hit_o, done_o;
    logic [43:0] ppn_o;
    logic [7:0]  perm_o;
    logic [1:0]  size_o;
    logic        refill_valid_i = 1'b0;
    logic [26:0] refill_vpn_i = '0;
    logic [15:0] refill_asid_i = '0;
    logic [1:0]  refill_size_i = '0;
    logic [43:0] refill_ppn_i = '0;
    logic [7:0]  refill_perm_i = '0;
    logic        flush_i = 1'b0;
    logic [26:0] flush_vpn_i = '0;
    logic [15:0] flush_asid_i = '0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        logic        hit;
        logic [43:0] ppn;
        logic [1:0]  sz;
        int          lat;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    tlb_hrh i_tlb_hrh (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid_i(lookup_valid_i), .lookup_vpn_i(lookup_vpn_i),
        .lookup_asid_i(lookup_asid_i), .walk_pending_i(walk_pending_i),
        .hit_o(hit_o), .done_o(done_o), .ppn_o(ppn_o), .perm_o(perm_o), .size_o(size_o),
        .refill_valid_i(refill_valid_i), .refill_vpn_i(refill_vpn_i),
        .refill_asid_i(refill_asid_i), .refill_size_i(refill_size_i),
        .refill_ppn_i(refill_ppn_i), .refill_perm_i(refill_perm_i),
        .flush_i(flush_i), .flush_vpn_i(flush_vpn_i), .flush_asid_i(flush_asid_i)
    );

    function automatic logic [26:0] mkvpn(input int v2, input int v1, input int v0);
        return {9'(v2), 9'(v1), 9'(v0)};
    endfunction

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    // Monitor: counts active probe cycles and compares each completion.
    always @(negedge clk) begin
        if (rst_n) begin
            if (lookup_valid_i && !walk_pending_i && !flush_i) cyc++;
            if (done_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4", "unexpected done_o: actual=1 expected=0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(hit_o == e.hit && cyc == e.lat, e.tag,
                          $sformatf("hit/latency actual=%0b/%0d expected=%0b/%0d",
                                    hit_o, cyc, e.hit, e.lat));
                    if (e.hit)
                        check(ppn_o == e.ppn && perm_o == e.ppn[7:0] && size_o == e.sz, e.tag,
                              $sformatf("ppn/perm/size actual=%h/%h/%0d expected=%h/%h/%0d",
                                        ppn_o, perm_o, size_o, e.ppn, e.ppn[7:0], e.sz));
                end
                cyc = 0;
            end
        end
    end

    task automatic do_lookup(input logic [26:0] vpn, input logic [15:0] asid,
                             input logic eh, input logic [43:0] eppn, input logic [1:0] esz,
                             input int elat, input int stall, input logic swap,
                             input logic [26:0] alt, input string tag);
        exp_t e;
        int n;
        e.hit = eh; e.ppn = eppn; e.sz = esz; e.lat = elat; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        lookup_valid_i = 1'b1; lookup_vpn_i = vpn; lookup_asid_i = asid;
        n = 0;
        forever begin
            @(negedge clk);
            if (done_o) break;
            @(posedge clk); #1;
            if (n == 0) begin
                walk_pending_i = (stall > 0);
                if (swap) lookup_vpn_i = alt;
            end
            if (n >= stall) walk_pending_i = 1'b0;
            n++;
        end
        @(posedge clk); #1;
        lookup_valid_i = 1'b0; walk_pending_i = 1'b0;
    endtask

    task automatic refill(input logic [26:0] vpn, input logic [15:0] asid,
                          input logic [1:0] sz, input logic [43:0] ppn);
        @(posedge clk); #1;
        refill_valid_i = 1'b1; refill_vpn_i = vpn; refill_asid_i = asid;
        refill_size_i = sz; refill_ppn_i = ppn; refill_perm_i = ppn[7:0];
        @(posedge clk); #1;
        refill_valid_i = 1'b0;
    endtask

    task automatic flush(input logic [26:0] vpn, input logic [15:0] asid);
        @(posedge clk); #1;
        flush_i = 1'b1; flush_vpn_i = vpn; flush_asid_i = asid;
        @(posedge clk); #1;
        flush_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [26:0] va, vb, vc, vd, ve, vf;
        va = mkvpn(1, 2, 3);  vb = mkvpn(1, 2, 11);
        vc = mkvpn(4, 0, 19); vd = mkvpn(0, 7, 27);
        ve = mkvpn(6, 6, 35); vf = mkvpn(2, 2, 4);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && !hit_o, "R1",
              $sformatf("idle outputs actual=%0b%0b expected=00", done_o, hit_o));

        do_lookup(va, 16'd5, 0, '0, 2'd0, 3, 0, 0, '0, "R1_R4 empty miss");

        // R8: four pages into 4K set 3 take the free ways
        refill(va, 16'd5, 2'd0, 44'h0A0);
        refill(vb, 16'd5, 2'd0, 44'h0B0);
        refill(vc, 16'd5, 2'd0, 44'h0C0);
        refill(vd, 16'd5, 2'd0, 44'h0D0);
        do_lookup(va, 16'd5, 1, 44'h0A0, 2'd0, 1, 0, 0, '0, "R2 4K hit first probe");
        do_lookup(va, 16'd6, 0, '0, 2'd0, 3, 0, 0, '0, "R5 asid mismatch");
        do_lookup(mkvpn(1, 3, 3), 16'd5, 0, '0, 2'd0, 3, 0, 0, '0, "R5 higher field mismatch");
        // R9: after A was hit, the next refill replaces C
        refill(ve, 16'd5, 2'd0, 44'h0E0);
        do_lookup(vc, 16'd5, 0, '0, 2'd0, 3, 0, 0, '0, "R9 victim evicted");
        do_lookup(vb, 16'd5, 1, 44'h0B0, 2'd0, 1, 0, 0, '0, "R8 B kept");
        do_lookup(vd, 16'd5, 1, 44'h0D0, 2'd0, 1, 0, 0, '0, "R8 D kept");
        do_lookup(ve, 16'd5, 1, 44'h0E0, 2'd0, 1, 0, 0, '0, "R9 E filled");
        do_lookup(va, 16'd5, 1, 44'h0A0, 2'd0, 1, 0, 0, '0, "R9 A kept");

        // R3: 2M and 1G pages
        refill(mkvpn(1, 5, 5), 16'd5, 2'd1, 44'h200);
        do_lookup(mkvpn(1, 5, 5), 16'd5, 1, 44'h200, 2'd1, 2, 0, 0, '0, "R3 2M not hit by 4K probe");
        do_lookup(mkvpn(1, 5, 100), 16'd5, 1, 44'h200, 2'd1, 2, 0, 0, '0, "R3 2M hit");
        refill(mkvpn(3, 0, 0), 16'd5, 2'd2, 44'h1000);
        do_lookup(mkvpn(3, 9, 9), 16'd5, 1, 44'h1000, 2'd2, 3, 0, 0, '0, "R3 1G hit");

        // R6: walk pending stalls the sequence
        do_lookup(mkvpn(3, 1, 1), 16'd5, 1, 44'h1000, 2'd2, 3, 3, 0, '0, "R6 stall");
        // R7: request change mid-sequence ignored
        do_lookup(mkvpn(3, 2, 2), 16'd5, 1, 44'h1000, 2'd2, 3, 0, 1, va, "R7 captured request");

        // R11: refill of F in the same cycle as a hit on A
        fork
            do_lookup(va, 16'd5, 1, 44'h0A0, 2'd0, 1, 0, 0, '0, "R11 hit with refill");
            refill(vf, 16'd5, 2'd0, 44'h0F0);
        join
        do_lookup(vf, 16'd5, 1, 44'h0F0, 2'd0, 1, 0, 0, '0, "R11 refill applied");

        // R10: selective then full flush
        flush(ve, 16'd5);
        do_lookup(ve, 16'd5, 0, '0, 2'd0, 3, 0, 0, '0, "R10 selective flush removes");
        do_lookup(va, 16'd5, 1, 44'h0A0, 2'd0, 1, 0, 0, '0, "R10 selective flush keeps");
        flush('0, 16'd0);
        do_lookup(va, 16'd5, 0, '0, 2'd0, 3, 0, 0, '0, "R10 flush all 4K");
        do_lookup(mkvpn(3, 9, 9), 16'd5, 0, '0, 2'd0, 3, 0, 0, '0, "R10 flush all 1G");

        repeat (2) @(posedge clk);
        check(sb.size() == 0, "R4",
              $sformatf("pending results actual=%0d expected=0", sb.size()));
        finish_run();
    end
endmodule